// File: doc/BRIEF.md
# Serial Control Register Port for an Audio Codec

This block is the configuration port of an audio codec. A host shifts 16-bit command words into it over a three-wire serial link: a clock, a data input and a frame-enable line that is held low for the length of a word. The block also drives a serial data output. Each word carries a register address, a direction flag and a 10-bit payload. When the frame-enable line returns high, a write word updates one of eleven mode registers. A read word has already returned the selected register on the output pin during that same word.

Two further addresses expose 6-bit peak levels that come from an external level detector. These two are read-only, and the value sits in the upper six bits of the 10-bit field. When a read of one of them completes, the block sends a one-cycle clear strobe back to the detector so that a new peak can build up. All eleven mode registers appear side by side on a parallel output bus for the rest of the codec. The serial pins are asynchronous to the system clock, so they are synchronised and edge-detected before use.

Top module: `codec_ctrl_port`

## Requirements
- R1: A word is sampled MSB first, one bit on each rising edge of `ser_clk` while `ser_latch` is low, and it takes effect on the rising edge of `ser_latch`. Bits 15:12 are the address. Bit 11 is the direction (0 = write, 1 = read). Bit 10 is reserved. Bits 9:0 are the data.
- R2: A word in which any bit count other than 16 was received before `ser_latch` rose is discarded without side effects.
- R3: A valid write to address 0..10 stores bits 9:0 into that register, which appears on `ctl_regs[10*a+9 : 10*a]`.
- R4: A write to address 11 or 12 changes nothing. A word with bit 10 set, or with an address of 13..15, is discarded with no register change and no strobe.
- R5: After reset, registers 2..7 (the six volume settings) hold 1023 and every other register holds 0.
- R6: A valid read of address 11 or 12 gives exactly one single-cycle pulse on `peak_clr[0]` or `peak_clr[1]` respectively, after `ser_latch` rises. No other word pulses either strobe.
- R7: During a valid read, `ser_dout` carries the register value in word bit positions 9..0, MSB first. Each bit is updated after the falling `ser_clk` edge that precedes the rising edge sampling that position. Address 11 returns {`peak_lvl[5:0]`,4'b0000} and address 12 returns {`peak_lvl[11:6]`,4'b0000}.
- R8: `ser_dout` is 0 in word positions 15..10, throughout any word that is not a valid read, and while `ser_latch` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock from the host, idle high |
| ser_latch | input | 1 | Frame enable, low during a word, rising edge commits |
| ser_din | input | 1 | Serial command data, MSB first |
| ser_dout | output | 1 | Serial read-back data |
| peak_lvl | input | 12 | Two 6-bit peak levels from the level detector |
| peak_clr | output | 2 | One-cycle clear-on-read strobes, one per peak level |
| ctl_regs | output | 110 | Eleven 10-bit mode registers, register a at bits 10a+9..10a |

## Verification
A bad bit count or a wrong header decode in this block shows up as a register update that should not happen. It appears on `ctl_regs` a few system clocks after `ser_latch` rises, and the per-clock model comparison catches it there. A wrong read-back selection or bit index shows up on `ser_dout` within the same word, at the first data bit position. A wrong strobe decode shows up as a missing, extra or wrongly routed `peak_clr` pulse, which is checked after every word.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  typedef enum logic {RW_WRITE = 1'b0, RW_READ = 1'b1} rw_e;

  function automatic int frame_len(input int aw, input int dw);
    return aw + 2 + dw;
  endfunction
endpackage

// File: rtl/ccp_sync.sv
module ccp_sync #(
  parameter int N = 3,
  parameter int STG = 2,
  parameter logic [N-1:0] RV = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STG:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {(STG+1){RV[i]}};
      else     chain <= {chain[STG-1:0], d[i]};
    end
    assign q[i]    = chain[STG-1];
    assign rise[i] = chain[STG-1] & ~chain[STG];
    assign fall[i] = ~chain[STG-1] & chain[STG];
  end
endmodule

// File: rtl/ccp_frame.sv
module ccp_frame
  import ccp_pkg::*;
#(
  parameter int AW  = 4,
  parameter int DW  = 10,
  parameter int NRW = 11,
  parameter int NPK = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  input  logic          lat_q,
  input  logic          lat_rise,
  input  logic          din_q,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [NPK-1:0] clr,
  output logic          dout
);
  localparam int FW  = frame_len(AW, DW);
  localparam int HDR = AW + 2;
  localparam int CW  = $clog2(FW + 2);
  localparam int IW  = $clog2(DW);
  localparam int NREG = NRW + NPK;

  logic [FW-1:0] sh;
  logic [CW-1:0] cnt;
  logic [DW-1:0] snap;
  logic          rd_act;

  // header view once HDR bits are in
  assign rd_addr = sh[HDR-1:2];
  logic hdr_rd;
  assign hdr_rd = (cnt == CW'(HDR)) && (sh[1] == RW_READ) && !sh[0] &&
                  (int'(sh[HDR-1:2]) < NREG);

  // full-word view at commit
  logic [AW-1:0] c_addr;
  logic          c_ok;
  assign c_addr = sh[FW-1 -: AW];
  assign c_ok   = (cnt == CW'(FW)) && !sh[DW] && (int'(c_addr) < NREG);

  logic [CW-1:0] idx;
  assign idx = CW'(FW - 1) - cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0;
      cnt <= '0;
    end else if (lat_q) begin
      cnt <= '0;
    end else if (sclk_rise) begin
      sh <= {sh[FW-2:0], din_q};
      if (cnt != CW'(FW + 1)) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      clr <= '0;
    end else begin
      wr_en <= 1'b0;
      clr <= '0;
      if (lat_rise && c_ok) begin
        if (sh[DW+1] == RW_WRITE) begin
          if (int'(c_addr) < NRW) begin
            wr_en <= 1'b1;
            wr_addr <= c_addr;
            wr_data <= sh[DW-1:0];
          end
        end else begin
          for (int k = 0; k < NPK; k++)
            if (int'(c_addr) == NRW + k) clr[k] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= 1'b0;
      rd_act <= 1'b0;
      snap <= '0;
    end else if (lat_q) begin
      dout <= 1'b0;
      rd_act <= 1'b0;
    end else if (sclk_fall) begin
      if (hdr_rd) begin
        snap <= rd_data;
        rd_act <= 1'b1;
        dout <= rd_data[DW-1];
      end else if (rd_act && cnt > CW'(HDR) && cnt < CW'(FW)) begin
        dout <= snap[idx[IW-1:0]];
      end else begin
        dout <= 1'b0;
      end
    end
  end

  AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (lat_q && $past(lat_q)) |-> !dout); // R8
  AST_DOUT_HDR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!lat_q && cnt < CW'(HDR) && $past(cnt) < CW'(HDR)) |-> !dout); // R7
endmodule

// File: rtl/ccp_regfile.sv
module ccp_regfile #(
  parameter int AW     = 4,
  parameter int DW     = 10,
  parameter int NRW    = 11,
  parameter int VOL_LO = 2,
  parameter int VOL_N  = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  output logic [NRW*DW-1:0] regs_flat
);
  for (genvar i = 0; i < NRW; i++) begin : g_reg
    localparam logic [DW-1:0] RST_VAL =
      (i >= VOL_LO && i < VOL_LO + VOL_N) ? {DW{1'b1}} : '0;
    logic [DW-1:0] r;
    always_ff @(posedge clk) begin
      if (rst) r <= RST_VAL;
      else if (wr_en && int'(wr_addr) == i) r <= wr_data;
    end
    assign regs_flat[i*DW +: DW] = r;
  end

  AST_WR_ADDR_OK: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> int'(wr_addr) < NRW); // R4
  AST_WR_LANDS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> regs_flat[int'($past(wr_addr))*DW +: DW] == $past(wr_data)); // R3
endmodule

// File: rtl/codec_ctrl_port.sv
module codec_ctrl_port #(
  parameter int AW     = 4,
  parameter int DW     = 10,
  parameter int NRW    = 11,
  parameter int NPK    = 2,
  parameter int PKW    = 6,
  parameter int VOL_LO = 2,
  parameter int VOL_N  = 6,
  parameter int SYNC   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ser_clk,
  input  logic               ser_latch,
  input  logic               ser_din,
  output logic               ser_dout,
  input  logic [NPK*PKW-1:0] peak_lvl,
  output logic [NPK-1:0]     peak_clr,
  output logic [NRW*DW-1:0]  ctl_regs
);
  logic [2:0] s_q, s_rise, s_fall;

  ccp_sync #(.N(3), .STG(SYNC), .RV(3'b011)) u_sync (
    .clk(clk), .rst(rst), .d({ser_din, ser_latch, ser_clk}),
    .q(s_q), .rise(s_rise), .fall(s_fall));

  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data, wr_data;
  logic          wr_en;

  ccp_frame #(.AW(AW), .DW(DW), .NRW(NRW), .NPK(NPK)) u_frame (
    .clk(clk), .rst(rst), .sclk_rise(s_rise[0]), .sclk_fall(s_fall[0]),
    .lat_q(s_q[1]), .lat_rise(s_rise[1]), .din_q(s_q[2]),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .clr(peak_clr), .dout(ser_dout));

  ccp_regfile #(.AW(AW), .DW(DW), .NRW(NRW), .VOL_LO(VOL_LO), .VOL_N(VOL_N)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .regs_flat(ctl_regs));

  always_comb begin
    int a;
    a = int'(rd_addr);
    rd_data = '0;
    if (a < NRW)
      rd_data = ctl_regs[a*DW +: DW];
    else if (a < NRW + NPK)
      rd_data = {peak_lvl[(a-NRW)*PKW +: PKW], {(DW-PKW){1'b0}}};
  end

  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(peak_clr)); // R6
  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (|peak_clr) |=> !(|peak_clr)); // R6
  AST_WR_CLR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (|peak_clr))); // R4
endmodule

// File: tb/tb_codec_ctrl_port.sv
`timescale 1ns/1ps
module tb_codec_ctrl_port;
  localparam int NRW = 11;
  localparam int DW = 10;
  localparam int HP = 6;

  logic clk = 0, rst = 1;
  logic ser_clk = 1, ser_latch = 1, ser_din = 0;
  logic ser_dout;
  logic [11:0] peak_lvl = {6'h15, 6'h2B};
  logic [1:0] peak_clr;
  logic [NRW*DW-1:0] ctl_regs;

  codec_ctrl_port dut (.clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_latch(ser_latch),
    .ser_din(ser_din), .ser_dout(ser_dout), .peak_lvl(peak_lvl),
    .peak_clr(peak_clr), .ctl_regs(ctl_regs));

  always #2.5 clk = ~clk;

  int total = 0, bad = 0, quiet = 1000;
  int got_clr0 = 0, got_clr1 = 0, exp_clr0 = 0, exp_clr1 = 0;
  logic [9:0] model [NRW];
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NRW*DW-1:0] model_flat();
    logic [NRW*DW-1:0] f;
    for (int i = 0; i < NRW; i++) f[i*DW +: DW] = model[i];
    return f;
  endfunction

  // per-clock reference comparison of the register bus (R3, R4, R2)
  always @(negedge clk) begin
    if (!rst) begin
      if (peak_clr[0]) got_clr0++;
      if (peak_clr[1]) got_clr1++;
      if (quiet > 0) quiet--;
      else begin
        total++;
        if (ctl_regs !== model_flat()) begin
          bad++;
          $display("FAIL R3 regs act=%h exp=%h", ctl_regs, model_flat());
        end
      end
    end
  end

  task automatic frame(input logic [31:0] v, input int n, input string tag);
    logic [3:0] a;
    bit rd_ok;
    logic [9:0] ev;
    a = v[15:12];
    rd_ok = (n == 16) && v[11] && !v[10] && a < 4'd13;
    ev = '0;
    if (rd_ok) begin
      if (a < 4'd11) ev = model[a];
      else if (a == 4'd11) ev = {peak_lvl[5:0], 4'b0};
      else ev = {peak_lvl[11:6], 4'b0};
    end
    @(negedge clk) ser_latch = 0;
    repeat (HP) @(negedge clk);
    for (int j = 0; j < n; j++) begin
      logic e;
      ser_din = v[n-1-j];
      ser_clk = 0;
      repeat (HP) @(negedge clk);
      e = (rd_ok && j >= 6 && j < 16) ? ev[15-j] : 1'b0;
      chk(ser_dout === e, $sformatf("R7/R8 %s dout pos %0d", tag, j), int'(ser_dout), int'(e));
      ser_clk = 1;
      repeat (HP) @(negedge clk);
    end
    quiet = 14;
    @(negedge clk);
    ser_latch = 1;
    if (n == 16 && !v[10] && a < 4'd13) begin
      if (!v[11] && a < 4'd11) model[a] = v[9:0];
      if (v[11] && a == 4'd11) exp_clr0++;
      if (v[11] && a == 4'd12) exp_clr1++;
    end
    repeat (20) @(negedge clk);
    chk(got_clr0 == exp_clr0, {"R6 clr0 ", tag}, got_clr0, exp_clr0);
    chk(got_clr1 == exp_clr1, {"R6 clr1 ", tag}, got_clr1, exp_clr1);
  endtask

  function automatic logic [31:0] w(input int a, input bit rd, input bit rsv, input int d);
    return {16'h0, 4'(a), rd, rsv, 10'(d)};
  endfunction

  initial begin
    for (int i = 0; i < NRW; i++) model[i] = (i >= 2 && i <= 7) ? 10'h3FF : 10'h000;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R5 reset defaults
    for (int i = 0; i < NRW; i++)
      chk(ctl_regs[i*DW +: DW] === model[i], $sformatf("R5 reset reg %0d", i),
          int'(ctl_regs[i*DW +: DW]), int'(model[i]));
    chk(ser_dout === 1'b0 && peak_clr === 2'b00, "R8 idle outputs", int'(ser_dout), 0);
    quiet = 0;
    // R1 R3 writes
    frame(w(0, 0, 0, 'h2A5), 16, "R3 wr0");
    frame(w(5, 0, 0, 'h013), 16, "R3 wr5");
    frame(w(10, 0, 0, 'h3FF), 16, "R3 wr10");
    frame(w(1, 0, 0, 'h155), 16, "R1 wr1");
    // R7 readbacks
    frame(w(0, 1, 0, 0), 16, "R7 rd0");
    frame(w(3, 1, 0, 0), 16, "R5 rd vol3");
    frame(w(10, 1, 0, 'h2AA), 16, "R7 rd10");
    // R4 read-only peaks and discards
    frame(w(11, 0, 0, 'h3FF), 16, "R4 wr11");
    frame(w(12, 0, 0, 'h155), 16, "R4 wr12");
    frame(w(11, 1, 0, 0), 16, "R6 rd11");
    frame(w(12, 1, 0, 0), 16, "R6 rd12");
    frame(w(1, 0, 1, 'h0F0), 16, "R4 rsv wr");
    frame(w(12, 1, 1, 0), 16, "R4 rsv rd12");
    frame(w(13, 0, 0, 'h111), 16, "R4 wr13");
    frame(w(15, 1, 0, 0), 16, "R4 rd15");
    // R2 wrong length
    frame({17'h0, 15'(w(4, 0, 0, 'h2C3) >> 1)}, 15, "R2 short");
    frame({w(6, 0, 0, 'h0AB), 1'b0} , 17, "R2 long");
    peak_lvl = {6'h3F, 6'h01};
    frame(w(11, 1, 0, 0), 16, "R7 rd11 new");
    frame(w(7, 0, 0, 'h000), 16, "R3 wr7");
    frame(w(7, 1, 0, 0), 16, "R7 rd7");
    repeat (20) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule